// File: doc/BRIEF.md
# Register-Mapped Serial Port Front End

This block sits between a simple word-wide read/write strobe bus and a separate serial framing engine. Software pushes outgoing characters into a 64-entry transmit queue through one word and pops incoming characters from a 64-entry receive queue through another. The framing engine drains the transmit queue through a valid/take handshake, delivers each received character with a strobe and two error indications, and takes its line configuration (control and baud words) from this block.

The block keeps three sticky error flags. They are cleared only by a control bit that software sets and must later write back to zero; while that bit is one the flags stay at zero. A single level interrupt combines a receive condition (queue fill at or above a programmable count) and a transmit condition (queue fill at or below a programmable count), each with its own enable. Two control bits flush the queues for as long as they are held high.

Top module: `uart_regblk`

## Requirements
- R1: After reset the control, threshold and baud words read as zero, both queues are empty, the status word reads 0x0050_0000 and `irq` is low.
- R2: Byte offsets are 0x00 transmit push, 0x04 receive pop, 0x08 control (all 32 bits kept), 0x0C status (read-only, writes ignored), 0x10 thresholds (bits 15:0 kept, upper bits read 0) and 0x14 baud (all 32 bits kept); `ctrl_word` and `baud_word` mirror the control and baud words.
- R3: A write to offset 0x00 queues bits 7:0 of the write data; `tx_valid` is high when control bit 12 is set and the queue holds data, `tx_data` shows the oldest entry, and `tx_take` while `tx_valid` removes it.
- R4: With control bit 13 set, `rx_strobe` queues `rx_data`; with bit 13 clear the strobe is ignored. A read of offset 0x04 returns the oldest entry in bits 7:0 with zeros above and removes it; a read of an empty queue returns 0.
- R5: Status bit 20 is receive queue empty, bit 21 transmit queue full (64 entries), bit 22 transmit queue empty and bit 25 follows `tx_busy`; the port is drained only when bit 22 is 1 and bit 25 is 0.
- R6: A transmit push while the transmit queue is full is dropped and sets sticky status bit 18; a character accepted while the receive queue is full is dropped and also sets bit 18.
- R7: An accepted character with `rx_par_err` sets sticky status bit 16 and one with `rx_frm_err` sets sticky bit 17; later clean characters leave them set.
- R8: Control bit 24 keeps the value written; while it is 1 status bits 16, 17 and 18 read 0 and new errors do not set them, and they stay 0 after the bit is written back to 0.
- R9: While control bit 22 (transmit) or bit 23 (receive) is 1 the matching queue is emptied and pushes to it are dropped; the other control bits read back unchanged.
- R10: The receive interrupt is active when control bit 27 is 1 and the receive queue count is at least threshold bits 7:0.
- R11: The transmit interrupt is active when control bit 28 is 1 and the transmit queue count is at most threshold bits 15:8; `irq` is the OR of the two and is low when both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe; pops the receive queue at offset 0x04 |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level interrupt |
| ctrl_word | output | 32 | Control word for the framing engine |
| baud_word | output | 32 | Baud configuration for the framing engine |
| tx_data | output | 8 | Oldest transmit queue entry |
| tx_valid | output | 1 | Transmit data available and transmitter enabled |
| tx_take | input | 1 | Framing engine consumes `tx_data` |
| tx_busy | input | 1 | Framing engine is shifting a character |
| rx_data | input | 8 | Received character |
| rx_strobe | input | 1 | `rx_data` is valid this cycle |
| rx_par_err | input | 1 | Parity error on the strobed character |
| rx_frm_err | input | 1 | Framing error on the strobed character |

## Verification
Register words are written and read back through a vector table to separate kept bits from dropped bits and read-only words from writable ones. The queues are driven through short ordered bursts, exact fill to 64 entries and one entry beyond, which tells ordering faults apart from off-by-one capacity faults and from a dropped-versus-overwritten overflow. Error flags are exercised with clean, parity and framing characters before, during and after the clear bit is held, separating stickiness from hold-clear behaviour. Interrupt thresholds are approached one entry at a time from both sides so that an at-least or at-most comparison shows up against a strict one.

// File: rtl/uart_regblk_pkg.sv
package uart_regblk_pkg;

    // control word bit positions
    localparam int CB_TX_EN   = 12;
    localparam int CB_RX_EN   = 13;
    localparam int CB_TX_RST  = 22;
    localparam int CB_RX_RST  = 23;
    localparam int CB_ERR_CLR = 24;
    localparam int CB_RX_IE   = 27;
    localparam int CB_TX_IE   = 28;

    // status word bit positions
    localparam int SB_PAR  = 16;
    localparam int SB_FRM  = 17;
    localparam int SB_OVR  = 18;
    localparam int SB_RXE  = 20;
    localparam int SB_TXF  = 21;
    localparam int SB_TXE  = 22;
    localparam int SB_BSY  = 25;

    localparam int THR_W = 8;

    typedef enum logic [2:0] {
        SEL_TXD,
        SEL_RXD,
        SEL_CTRL,
        SEL_STAT,
        SEL_THR,
        SEL_BAUD,
        SEL_NONE
    } reg_sel_e;

    typedef struct packed {
        logic tx_en;
        logic rx_en;
        logic tx_flush;
        logic rx_flush;
        logic err_clr;
        logic rx_ie;
        logic tx_ie;
    } ctrl_fields_t;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
    } err_flags_t;

    function automatic reg_sel_e decode_sel(input int unsigned widx, input logic aligned);
        reg_sel_e s;
        if (!aligned) begin
            s = SEL_NONE;
        end else begin
            case (widx)
                0:       s = SEL_TXD;
                1:       s = SEL_RXD;
                2:       s = SEL_CTRL;
                3:       s = SEL_STAT;
                4:       s = SEL_THR;
                5:       s = SEL_BAUD;
                default: s = SEL_NONE;
            endcase
        end
        return s;
    endfunction

    function automatic ctrl_fields_t decode_ctrl(input logic [31:0] c);
        ctrl_fields_t f;
        f.tx_en    = c[CB_TX_EN];
        f.rx_en    = c[CB_RX_EN];
        f.tx_flush = c[CB_TX_RST];
        f.rx_flush = c[CB_RX_RST];
        f.err_clr  = c[CB_ERR_CLR];
        f.rx_ie    = c[CB_RX_IE];
        f.tx_ie    = c[CB_TX_IE];
        return f;
    endfunction

    function automatic logic [31:0] pack_status(input err_flags_t e, input logic rx_empty,
                                                input logic tx_full, input logic tx_empty,
                                                input logic busy);
        logic [31:0] s;
        s         = '0;
        s[SB_PAR] = e.par;
        s[SB_FRM] = e.frm;
        s[SB_OVR] = e.ovr;
        s[SB_RXE] = rx_empty;
        s[SB_TXF] = tx_full;
        s[SB_TXE] = tx_empty;
        s[SB_BSY] = busy;
        return s;
    endfunction

endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         empty,
    output logic                         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (do_pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/uart_err_track.sv
module uart_err_track
    import uart_regblk_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  err_flags_t set_flags,
    output err_flags_t flags
);
    // sticky flags; the clear input dominates for every cycle it is high
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            flags <= '0;
        end else begin
            flags <= flags | set_flags;
        end
    end
endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen #(
    parameter int CNT_W = 7,
    parameter int THR_W = 8
) (
    input  logic [CNT_W-1:0] rx_count,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [THR_W-1:0] tx_thr,
    input  logic             rx_ie,
    input  logic             tx_ie,
    output logic             irq
);
    localparam int CMP_W = ((CNT_W > THR_W) ? CNT_W : THR_W) + 1;

    logic rx_hit, tx_hit;

    always_comb begin
        rx_hit = rx_ie && (CMP_W'(rx_count) >= CMP_W'(rx_thr));
        tx_hit = tx_ie && (CMP_W'(tx_count) <= CMP_W'(tx_thr));
        irq    = rx_hit || tx_hit;
    end
endmodule

// File: rtl/uart_regblk.sv
module uart_regblk
    import uart_regblk_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       baud_word,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_take,
    input  logic              tx_busy,
    input  logic [7:0]        rx_data,
    input  logic              rx_strobe,
    input  logic              rx_par_err,
    input  logic              rx_frm_err
);
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int THR_BITS = 2 * THR_W;

    logic [31:0]         ctrl_q;
    logic [THR_BITS-1:0] thr_q;
    logic [31:0]         baud_q;

    reg_sel_e     sel;
    ctrl_fields_t cf;
    err_flags_t   err_set, err_q;

    logic             tx_push, tx_pop, tx_empty, tx_full;
    logic             rx_push, rx_pop, rx_empty, rx_full, rx_accept;
    logic [7:0]       tx_head, rx_head;
    logic [CNT_W-1:0] tx_count, rx_count;

    assign sel = decode_sel(int'(bus_addr[ADDR_W-1:2]), bus_addr[1:0] == 2'b00);
    assign cf  = decode_ctrl(ctrl_q);

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            thr_q  <= '0;
            baud_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                SEL_CTRL: ctrl_q <= bus_wdata;
                SEL_THR:  thr_q  <= bus_wdata[THR_BITS-1:0];
                SEL_BAUD: baud_q <= bus_wdata;
                default:  ;
            endcase
        end
    end

    // queue control
    assign tx_push   = bus_wr && (sel == SEL_TXD);
    assign tx_valid  = cf.tx_en && !tx_empty;
    assign tx_pop    = tx_take && tx_valid;
    assign tx_data   = tx_head;
    assign rx_accept = rx_strobe && cf.rx_en;
    assign rx_push   = rx_accept;
    assign rx_pop    = bus_rd && (sel == SEL_RXD);

    always_comb begin
        err_set.ovr = (tx_push && tx_full && !cf.tx_flush) ||
                      (rx_accept && rx_full && !cf.rx_flush);
        err_set.par = rx_accept && rx_par_err;
        err_set.frm = rx_accept && rx_frm_err;
    end

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
        .clk      (clk),
        .rst      (rst),
        .flush    (cf.tx_flush),
        .push     (tx_push),
        .push_data(bus_wdata[7:0]),
        .pop      (tx_pop),
        .head     (tx_head),
        .count    (tx_count),
        .empty    (tx_empty),
        .full     (tx_full)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
        .clk      (clk),
        .rst      (rst),
        .flush    (cf.rx_flush),
        .push     (rx_push),
        .push_data(rx_data),
        .pop      (rx_pop),
        .head     (rx_head),
        .count    (rx_count),
        .empty    (rx_empty),
        .full     (rx_full)
    );

    uart_err_track u_err (
        .clk      (clk),
        .rst      (rst),
        .clr      (cf.err_clr),
        .set_flags(err_set),
        .flags    (err_q)
    );

    uart_irq_gen #(.CNT_W(CNT_W), .THR_W(THR_W)) u_irq (
        .rx_count(rx_count),
        .tx_count(tx_count),
        .rx_thr  (thr_q[THR_W-1:0]),
        .tx_thr  (thr_q[THR_BITS-1:THR_W]),
        .rx_ie   (cf.rx_ie),
        .tx_ie   (cf.tx_ie),
        .irq     (irq)
    );

    // read mux
    always_comb begin
        case (sel)
            SEL_RXD:  bus_rdata = rx_empty ? 32'd0 : {24'd0, rx_head};
            SEL_CTRL: bus_rdata = ctrl_q;
            SEL_STAT: bus_rdata = pack_status(err_q, rx_empty, tx_full, tx_empty, tx_busy);
            SEL_THR:  bus_rdata = 32'(thr_q);
            SEL_BAUD: bus_rdata = baud_q;
            default:  bus_rdata = 32'd0;
        endcase
    end

    assign ctrl_word = ctrl_q;
    assign baud_word = baud_q;
endmodule

// File: rtl/uart_regblk_chk.sv
module uart_regblk_chk #(
    parameter int DEPTH = 64,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_tx,
    input logic             clr,
    input logic             rx_ie,
    input logic             tx_ie,
    input logic [7:0]       thr_rx,
    input logic [CNT_W-1:0] tx_count,
    input logic [CNT_W-1:0] rx_count,
    input logic             tx_empty,
    input logic             rx_empty,
    input logic             tx_full,
    input logic [2:0]       err,
    input logic             tx_push,
    input logic             tx_valid,
    input logic             tx_take,
    input logic             irq
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (tx_count <= CNT_W'(DEPTH)) && (rx_count <= CNT_W'(DEPTH))); // R3
    AST_LAST_POP: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_take && tx_count == CNT_W'(1) && !tx_push) |=> !tx_valid); // R3
    AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_full && !flush_tx && !clr) |=> err[2]); // R6
    AST_PAR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err[0] && !clr) |=> err[0]); // R7
    AST_CLEAR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (err == 3'b000)); // R8
    AST_TX_FLUSH: assert property (@(posedge clk) disable iff (rst)
        flush_tx |=> tx_empty); // R9
    AST_RX_IRQ: assert property (@(posedge clk) disable iff (rst)
        (rx_ie && !rx_empty && thr_rx == 8'd1) |-> irq); // R10
    AST_TX_IRQ: assert property (@(posedge clk) disable iff (rst)
        (tx_ie && tx_empty) |-> irq); // R11
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rx_ie && !tx_ie) |-> !irq); // R11
endmodule

bind uart_regblk uart_regblk_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flush_tx(cf.tx_flush),
    .clr     (cf.err_clr),
    .rx_ie   (cf.rx_ie),
    .tx_ie   (cf.tx_ie),
    .thr_rx  (thr_q[7:0]),
    .tx_count(tx_count),
    .rx_count(rx_count),
    .tx_empty(tx_empty),
    .rx_empty(rx_empty),
    .tx_full (tx_full),
    .err     (err_q),
    .tx_push (tx_push),
    .tx_valid(tx_valid),
    .tx_take (tx_take),
    .irq     (irq)
);

// File: tb/sim_uart_regblk.sv
module sim_uart_regblk;
    localparam int ADDR_W = 5;
    localparam logic [4:0] A_TXD = 5'h00, A_RXD = 5'h04, A_CTRL = 5'h08,
                           A_STAT = 5'h0C, A_THR = 5'h10, A_BAUD = 5'h14;
    localparam logic [31:0] ST_IDLE = 32'h0050_0000;
    localparam logic [31:0] C_TXEN = 32'h0000_1000, C_RXEN = 32'h0000_2000,
                            C_TXRST = 32'h0040_0000, C_RXRST = 32'h0080_0000,
                            C_CLR = 32'h0100_0000, C_RXIE = 32'h0800_0000,
                            C_TXIE = 32'h1000_0000;

    // register vector table: address, write data, expected read-back
    localparam int NV = 6;
    localparam logic [4:0]  V_ADDR [NV] = '{A_CTRL, A_THR, A_BAUD, A_STAT, A_RXD, A_CTRL};
    localparam logic [31:0] V_WR   [NV] = '{32'h1234_5678, 32'hDEAD_BEEF, 32'hA5A5_0F0F,
                                            32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0000};
    localparam logic [31:0] V_EXP  [NV] = '{32'h1234_5678, 32'h0000_BEEF, 32'hA5A5_0F0F,
                                            ST_IDLE, 32'h0000_0000, 32'h0000_0000};

    logic clk = 1'b0, rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;
    logic [31:0] ctrl_word, baud_word;
    logic [7:0] tx_data;
    logic tx_valid, tx_take = 1'b0, tx_busy = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_strobe = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;

    int checks = 0, fails = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    uart_regblk #(.DEPTH(64), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .ctrl_word(ctrl_word),
        .baud_word(baud_word), .tx_data(tx_data), .tx_valid(tx_valid), .tx_take(tx_take),
        .tx_busy(tx_busy), .rx_data(rx_data), .rx_strobe(rx_strobe),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rx_send(input logic [7:0] b, input logic pe, input logic fe);
        @(negedge clk);
        rx_strobe = 1'b1; rx_data = b; rx_par_err = pe; rx_frm_err = fe;
        @(negedge clk);
        rx_strobe = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
    endtask

    task automatic tx_pop1;
        @(negedge clk);
        tx_take = 1'b1;
        @(negedge clk);
        tx_take = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        logic ok;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(A_STAT, v); check("R1 status", v, ST_IDLE);
        rd(A_CTRL, v); check("R1 ctrl", v, 32'd0);
        rd(A_THR, v);  check("R1 thr", v, 32'd0);
        check("R1 irq", {31'd0, irq}, 32'd0);

        // R2 register table
        for (int i = 0; i < NV; i++) begin
            wr(V_ADDR[i], V_WR[i]);
            rd(V_ADDR[i], v);
            check($sformatf("R2 vec%0d", i), v, V_EXP[i]);
        end
        check("R2 baud_word", baud_word, 32'hA5A5_0F0F);
        wr(A_CTRL, C_RXEN); check("R2 ctrl_word", ctrl_word, C_RXEN);
        wr(A_CTRL, 32'd0);

        // R3 transmit ordering and enable
        wr(A_TXD, 32'hFFFF_FF41); wr(A_TXD, 32'h42); wr(A_TXD, 32'h43);
        check("R3 valid gated by enable", {31'd0, tx_valid}, 32'd0);
        rd(A_STAT, v); check("R3 tx not empty", v, 32'h0010_0000);
        wr(A_CTRL, C_TXEN);
        check("R3 valid", {31'd0, tx_valid}, 32'd1);
        check("R3 first", {24'd0, tx_data}, 32'h41);
        tx_pop1; check("R3 second", {24'd0, tx_data}, 32'h42);
        tx_pop1; check("R3 third", {24'd0, tx_data}, 32'h43);
        tx_pop1; check("R3 drained valid", {31'd0, tx_valid}, 32'd0);
        rd(A_STAT, v); check("R3 status empty", v, ST_IDLE);

        // R5 busy flag
        tx_busy = 1'b1;
        rd(A_STAT, v); check("R5 busy not drained", v, ST_IDLE | 32'h0200_0000);
        tx_busy = 1'b0;

        // R6 transmit overflow drop
        wr(A_CTRL, 32'd0);
        for (int i = 0; i < 64; i++) wr(A_TXD, 32'(i));
        rd(A_STAT, v); check("R5 tx full no error", v, 32'h0030_0000);
        wr(A_TXD, 32'hEE);
        rd(A_STAT, v); check("R6 tx write error", v, 32'h0034_0000);
        wr(A_CTRL, C_TXEN);
        for (int i = 0; i < 63; i++) tx_pop1;
        check("R6 dropped byte absent", {24'd0, tx_data}, 32'd63);
        tx_pop1; check("R6 empty after 64", {31'd0, tx_valid}, 32'd0);

        // R8 clear bit held
        wr(A_CTRL, C_CLR | C_RXEN);
        rd(A_STAT, v); check("R8 cleared", v, ST_IDLE);
        rx_send(8'h5A, 1'b1, 1'b1);
        rd(A_STAT, v); check("R8 no set while held", v & 32'h0007_0000, 32'd0);
        rd(A_CTRL, v); check("R8 bit persists", v, C_CLR | C_RXEN);
        wr(A_CTRL, C_RXEN);
        rd(A_STAT, v); check("R8 stays clear", v & 32'h0007_0000, 32'd0);

        // R9 receive flush
        check("R9 pre flush", v & 32'h0010_0000, 32'd0);
        wr(A_CTRL, C_RXRST | C_RXEN);
        rd(A_STAT, v); check("R9 rx emptied", v & 32'h0010_0000, 32'h0010_0000);
        rx_send(8'h77, 1'b0, 1'b0);
        rd(A_STAT, v); check("R9 push dropped", v & 32'h0010_0000, 32'h0010_0000);
        rd(A_CTRL, v); check("R9 ctrl intact", v, C_RXRST | C_RXEN);
        wr(A_CTRL, C_RXEN);

        // R7 sticky parity and frame
        rx_send(8'h11, 1'b1, 1'b0);
        rd(A_STAT, v); check("R7 parity set", v & 32'h0007_0000, 32'h0001_0000);
        rx_send(8'h22, 1'b0, 1'b0);
        rd(A_STAT, v); check("R7 parity sticky", v & 32'h0007_0000, 32'h0001_0000);
        rx_send(8'h33, 1'b0, 1'b1);
        rd(A_STAT, v); check("R7 frame set", v & 32'h0007_0000, 32'h0003_0000);

        // R4 receive read order
        rd(A_RXD, v); check("R4 read 1", v, 32'h11);
        rd(A_RXD, v); check("R4 read 2", v, 32'h22);
        rd(A_RXD, v); check("R4 read 3", v, 32'h33);
        rd(A_RXD, v); check("R4 empty read", v, 32'd0);
        wr(A_CTRL, 32'd0);
        rx_send(8'h44, 1'b0, 1'b0);
        rd(A_STAT, v); check("R4 disabled ignored", v & 32'h0010_0000, 32'h0010_0000);

        // R6 receive overrun
        wr(A_CTRL, C_CLR); wr(A_CTRL, C_RXEN);
        for (int i = 0; i < 65; i++) rx_send(8'(i + 8'h80), 1'b0, 1'b0);
        rd(A_STAT, v); check("R6 rx overrun", v & 32'h0017_0000, 32'h0004_0000);
        ok = 1'b1;
        for (int i = 0; i < 64; i++) begin
            rd(A_RXD, v);
            if (v !== 32'(8'(i + 8'h80))) ok = 1'b0;
        end
        check("R6 rx kept first 64", {31'd0, ok}, 32'd1);
        rd(A_RXD, v); check("R6 rx 65th dropped", v, 32'd0);

        // R10 receive threshold
        wr(A_CTRL, C_CLR); wr(A_THR, 32'h0000_0003); wr(A_CTRL, C_RXEN | C_RXIE);
        rx_send(8'h01, 1'b0, 1'b0); rx_send(8'h02, 1'b0, 1'b0);
        check("R10 below thr", {31'd0, irq}, 32'd0);
        rx_send(8'h03, 1'b0, 1'b0);
        check("R10 at thr", {31'd0, irq}, 32'd1);
        rd(A_RXD, v);
        check("R10 below again", {31'd0, irq}, 32'd0);
        wr(A_CTRL, C_RXRST); wr(A_CTRL, 32'd0);

        // R11 transmit threshold
        wr(A_THR, 32'h0000_0200); wr(A_CTRL, C_TXIE);
        check("R11 empty fires", {31'd0, irq}, 32'd1);
        wr(A_TXD, 32'h1); wr(A_TXD, 32'h2); wr(A_TXD, 32'h3);
        check("R11 above thr", {31'd0, irq}, 32'd0);
        wr(A_CTRL, C_TXIE | C_TXEN);
        tx_pop1;
        check("R11 at thr", {31'd0, irq}, 32'd1);
        wr(A_CTRL, C_TXEN);
        check("R11 disabled quiet", {31'd0, irq}, 32'd0);

        // R9 transmit flush
        wr(A_CTRL, C_TXRST);
        rd(A_STAT, v); check("R9 tx flushed", v, ST_IDLE);
        wr(A_CTRL, 32'd0);

        // R1 reset mid-run
        wr(A_CTRL, C_TXIE); wr(A_TXD, 32'h9);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        rd(A_STAT, v); check("R1 reset status", v, ST_IDLE);
        check("R1 reset ctrl", ctrl_word, 32'd0);
        check("R1 reset irq", {31'd0, irq}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule